// File: doc/BRIEF.md
# Supervisor Reset Sequencer

This block merges three reset requests into a single pair of complementary reset outputs. The requests are a supply-fault flag, a mechanical push-button, and a watchdog expiry pulse. The supply-fault flag is already synchronous and digitized. The push-button is active-low, asynchronous and bouncy. Any request drives reset active. Reset then stays active until every request has gone quiet and a fixed hold interval has elapsed after that.

The push-button first passes through a two-flop synchronizer. A qualification counter follows it, so that short glitches are rejected and a sustained press is accepted. A single shared hold counter stretches every request into a reset of at least the hold length. Any request seen while the counter runs sends it back to zero.

Time is given in milliseconds. A parameter sets the number of clock cycles per millisecond, so a testbench can shrink every interval. A status output reports when reset is released. A companion watchdog uses this output to start its timing.

Top module: `supv_reset_seq`

## Requirements
- R1: After the synchronous block reset `rst`, `reset_hi` is 1 and `reset_lo_n` is 0. They release only after HOLD_MS*CYC_PER_MS consecutive clock cycles with no request.
- R2: When `supply_bad` is 1 at a rising edge, `reset_hi` is 1 from the second rising edge after that edge onward. This latency comes from the hold register plus the output register.
- R3: Reset is released only after HOLD_MS*CYC_PER_MS consecutive sampled cycles with no request. A new `supply_bad` pulse during the hold restarts the count from zero.
- R4: A press is recognized when the synchronized `btn_n` has been sampled 0 on QUAL_MS*CYC_PER_MS consecutive edges. The synchronizer adds two flops of delay before this count starts. A recognized press forces reset active.
- R5: A low level on `btn_n` that gives fewer than QUAL_MS*CYC_PER_MS consecutive low samples has no effect on the outputs. QUAL_MS is restricted to lie between REJECT_MS (1 ms) and ACCEPT_MS (20 ms).
- R6: After the recognized `btn_n` returns to 1, reset stays active for a further HOLD_MS*CYC_PER_MS cycles.
- R7: A one-cycle pulse of 1 on `wdt_expire` drives reset active for at least HOLD_MS*CYC_PER_MS cycles.
- R8: `reset_lo_n` is always the inverse of `reset_hi`, and `run_ok` equals `reset_lo_n`. All three are registered outputs.
- R9: Suppose a request is sampled on the very edge at which the hold would otherwise expire. Then the request wins: reset stays active and the hold restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock |
| rst | input | 1 | Synchronous active-high block reset |
| supply_bad | input | 1 | Synchronous supply-out-of-tolerance flag, 1 = fault |
| btn_n | input | 1 | Asynchronous push-button, 0 = pressed |
| wdt_expire | input | 1 | Watchdog expiry pulse, 1 = expired |
| reset_hi | output | 1 | Reset, active high |
| reset_lo_n | output | 1 | Reset, active low |
| run_ok | output | 1 | 1 when reset is released (watchdog enable) |

## Verification
The hold expiry and a fresh request can fall on the same clock edge. The bench provokes this on purpose. It raises a supply fault and drops it again, then counts out exactly the hold length minus one cycles. It fires the watchdog pulse so that the pulse is sampled on the edge where the counter would release reset. The behavioural model counts quiet cycles and predicts that reset stays active. The bench compares every cycle and also makes a directed check just past the would-be release point. A design that lets the expiry win shows up as reset dropping there.

// File: rtl/supv_pkg.sv
package supv_pkg;
  typedef enum logic {
    HOLD_ASSERTED = 1'b1,
    HOLD_RELEASED = 1'b0
  } hold_state_e;

  function automatic int ms_to_cycles(input int ms, input int cyc_per_ms);
    return ms * cyc_per_ms;
  endfunction
endpackage

// File: rtl/supv_sync2.sv
module supv_sync2 #(
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d_async,
  output logic q_sync
);
  logic meta_q, sync_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= RESET_VAL;
      sync_q <= RESET_VAL;
    end else begin
      meta_q <= d_async;
      sync_q <= meta_q;
    end
  end

  assign q_sync = sync_q;
endmodule

// File: rtl/supv_btn_qual.sv
module supv_btn_qual #(
  parameter int QUAL_CYC = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic btn_sync_n,
  output logic pressed
);
  localparam int CNT_W = (QUAL_CYC > 1) ? $clog2(QUAL_CYC) : 1;

  logic [CNT_W-1:0] low_cnt;
  logic             pressed_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      low_cnt   <= '0;
      pressed_q <= 1'b0;
    end else if (btn_sync_n) begin
      low_cnt   <= '0;
      pressed_q <= 1'b0;
    end else if (!pressed_q) begin
      if (low_cnt == CNT_W'(QUAL_CYC - 1)) begin
        pressed_q <= 1'b1;
      end else begin
        low_cnt <= low_cnt + 1'b1;
      end
    end
  end

  assign pressed = pressed_q;

  // R6: a high level on the synchronized button always clears the press
  assert_release_on_high_R6: assert property (@(posedge clk) disable iff (rst)
    btn_sync_n |=> !pressed_q);
  // R5: a press can only be recognized while the button is low
  assert_press_needs_low_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(pressed_q) |-> !$past(btn_sync_n));
endmodule

// File: rtl/supv_hold_timer.sv
module supv_hold_timer
  import supv_pkg::*;
#(
  parameter int HOLD_CYC = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic req,
  output logic active
);
  localparam int CNT_W = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;

  hold_state_e      state_q;
  logic [CNT_W-1:0] quiet_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= HOLD_ASSERTED;
      quiet_cnt <= '0;
    end else if (req) begin
      state_q   <= HOLD_ASSERTED;
      quiet_cnt <= '0;
    end else if (state_q == HOLD_ASSERTED) begin
      if (quiet_cnt == CNT_W'(HOLD_CYC - 1)) begin
        state_q   <= HOLD_RELEASED;
        quiet_cnt <= '0;
      end else begin
        quiet_cnt <= quiet_cnt + 1'b1;
      end
    end
  end

  assign active = (state_q == HOLD_ASSERTED);

  // R2: any request leaves the hold asserted on the next cycle
  assert_req_asserts_R2: assert property (@(posedge clk) disable iff (rst)
    req |=> active);
  // R3: release never happens on an edge that sampled a request (R9)
  assert_release_quiet_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(active) |-> !$past(req));
endmodule

// File: rtl/supv_out_drive.sv
module supv_out_drive (
  input  logic clk,
  input  logic rst,
  input  logic active,
  output logic reset_hi,
  output logic reset_lo_n,
  output logic run_ok
);
  logic hi_q, lo_n_q, ok_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q   <= 1'b1;
      lo_n_q <= 1'b0;
      ok_q   <= 1'b0;
    end else begin
      hi_q   <= active;
      lo_n_q <= !active;
      ok_q   <= !active;
    end
  end

  assign reset_hi   = hi_q;
  assign reset_lo_n = lo_n_q;
  assign run_ok     = ok_q;

  // R8: the two reset polarities never agree
  assert_complement_R8: assert property (@(posedge clk) disable iff (rst)
    hi_q != lo_n_q);
  // R8: status follows the active-low output
  assert_status_R8: assert property (@(posedge clk) disable iff (rst)
    ok_q == lo_n_q);
endmodule

// File: rtl/supv_reset_seq.sv
module supv_reset_seq
  import supv_pkg::*;
#(
  parameter int CYC_PER_MS = 125000,
  parameter int HOLD_MS    = 250,
  parameter int REJECT_MS  = 1,
  parameter int ACCEPT_MS  = 20,
  parameter int QUAL_MS    = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic supply_bad,
  input  logic btn_n,
  input  logic wdt_expire,
  output logic reset_hi,
  output logic reset_lo_n,
  output logic run_ok
);
  localparam int HOLD_CYC = ms_to_cycles(HOLD_MS, CYC_PER_MS);
  localparam int QUAL_CYC = ms_to_cycles(QUAL_MS, CYC_PER_MS);

  generate
    if (QUAL_MS < REJECT_MS || QUAL_MS > ACCEPT_MS) begin : g_bad_qual
      initial $error("QUAL_MS must lie between REJECT_MS and ACCEPT_MS");
    end
  endgenerate

  logic btn_sync_n;
  logic btn_pressed;
  logic any_req;
  logic hold_active;

  supv_sync2 #(.RESET_VAL(1'b1)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .d_async (btn_n),
    .q_sync  (btn_sync_n)
  );

  supv_btn_qual #(.QUAL_CYC(QUAL_CYC)) u_qual (
    .clk        (clk),
    .rst        (rst),
    .btn_sync_n (btn_sync_n),
    .pressed    (btn_pressed)
  );

  assign any_req = supply_bad | btn_pressed | wdt_expire;

  supv_hold_timer #(.HOLD_CYC(HOLD_CYC)) u_hold (
    .clk    (clk),
    .rst    (rst),
    .req    (any_req),
    .active (hold_active)
  );

  supv_out_drive u_out (
    .clk        (clk),
    .rst        (rst),
    .active     (hold_active),
    .reset_hi   (reset_hi),
    .reset_lo_n (reset_lo_n),
    .run_ok     (run_ok)
  );

  // R7: a watchdog pulse reaches the output two edges later
  assert_wdt_forces_R7: assert property (@(posedge clk) disable iff (rst)
    wdt_expire |-> ##2 reset_hi);
  // R2: a supply fault reaches the output two edges later
  assert_supply_forces_R2: assert property (@(posedge clk) disable iff (rst)
    supply_bad |-> ##2 reset_hi);
endmodule

// File: tb/supv_reset_seq_test.sv
module supv_reset_seq_test;
  localparam int CPM  = 4;
  localparam int HOLD = 250 * CPM;
  localparam int QUAL = 5 * CPM;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic supply_bad = 1'b0;
  logic btn_n = 1'b1;
  logic wdt_expire = 1'b0;
  logic reset_hi, reset_lo_n, run_ok;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  string cur_req = "R1";

  always #4 clk = ~clk;

  supv_reset_seq #(.CYC_PER_MS(CPM), .HOLD_MS(250), .REJECT_MS(1),
                   .ACCEPT_MS(20), .QUAL_MS(5)) uut (
    .clk(clk), .rst(rst), .supply_bad(supply_bad), .btn_n(btn_n),
    .wdt_expire(wdt_expire), .reset_hi(reset_hi), .reset_lo_n(reset_lo_n),
    .run_ok(run_ok)
  );

  // Behavioural reference: delay queue, run counters, one output delay
  logic btn_q[$];
  int   low_run, quiet_run;
  logic m_out;

  always @(posedge clk) begin
    logic btn_seen;
    logic pressed_now;
    logic req;
    if (rst) begin
      btn_q = {1'b1, 1'b1};
      low_run = 0;
      quiet_run = 0;
      m_out = 1'b1;
    end else begin
      pressed_now = (low_run >= QUAL);
      req = supply_bad | pressed_now | wdt_expire;
      m_out = (quiet_run < HOLD);
      if (req) quiet_run = 0;
      else if (quiet_run < HOLD) quiet_run++;
      btn_seen = btn_q.pop_front();
      if (btn_seen) low_run = 0;
      else if (low_run < QUAL) low_run++;
      btn_q.push_back(btn_n);
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (!rst) begin
      checks++;
      if (reset_hi !== m_out || reset_lo_n !== !m_out) begin
        errors++;
        $display("FAIL %s cycle %0d: reset_hi=%b reset_lo_n=%b expected %b/%b",
                 cur_req, cycles, reset_hi, reset_lo_n, m_out, !m_out);
      end
      checks++;
      if (run_ok !== reset_lo_n) begin
        errors++;
        $display("FAIL R8 cycle %0d: run_ok=%b expected %b", cycles, run_ok, reset_lo_n);
      end
    end
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: run hung at cycle %0d expected end", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_hi(input logic exp, input string req);
    checks++;
    if (reset_hi !== exp) begin
      errors++;
      $display("FAIL %s: reset_hi=%b expected %b", req, reset_hi, exp);
    end
  endtask

  initial begin
    wait_cyc(5);
    checks++;
    if (reset_hi !== 1'b1 || reset_lo_n !== 1'b0 || run_ok !== 1'b0) begin
      errors++;
      $display("FAIL R1: reset state %b%b%b expected 100", reset_hi, reset_lo_n, run_ok);
    end
    rst = 1'b0;
    cur_req = "R1";
    wait_cyc(HOLD - 10);
    expect_hi(1'b1, "R1");
    wait_cyc(20);
    expect_hi(1'b0, "R1");

    // R2 / R3: supply fault and restart
    cur_req = "R2";
    supply_bad = 1'b1; wait_cyc(1); supply_bad = 1'b0;
    wait_cyc(2);
    expect_hi(1'b1, "R2");
    cur_req = "R3";
    wait_cyc(500);
    supply_bad = 1'b1; wait_cyc(1); supply_bad = 1'b0;
    wait_cyc(HOLD - 10);
    expect_hi(1'b1, "R3");
    wait_cyc(20);
    expect_hi(1'b0, "R3");

    // R5: rejected presses, including one sample short of the limit
    cur_req = "R5";
    btn_n = 1'b0; wait_cyc(CPM); btn_n = 1'b1;
    wait_cyc(30);
    expect_hi(1'b0, "R5");
    btn_n = 1'b0; wait_cyc(QUAL - 1); btn_n = 1'b1;
    wait_cyc(30);
    expect_hi(1'b0, "R5");

    // R4 / R6: accepted press held, then hold after release
    cur_req = "R4";
    btn_n = 1'b0; wait_cyc(QUAL + 4);
    expect_hi(1'b1, "R4");
    wait_cyc(100);
    cur_req = "R6";
    btn_n = 1'b1;
    wait_cyc(HOLD - 10);
    expect_hi(1'b1, "R6");
    wait_cyc(20);
    expect_hi(1'b0, "R6");

    // R7: watchdog pulse
    cur_req = "R7";
    wdt_expire = 1'b1; wait_cyc(1); wdt_expire = 1'b0;
    wait_cyc(2);
    expect_hi(1'b1, "R7");
    wait_cyc(HOLD - 10);
    expect_hi(1'b1, "R7");
    wait_cyc(20);
    expect_hi(1'b0, "R7");

    // R9: watchdog pulse on the edge the hold would expire
    cur_req = "R9";
    supply_bad = 1'b1; wait_cyc(1); supply_bad = 1'b0;
    wait_cyc(HOLD - 1);
    wdt_expire = 1'b1; wait_cyc(1); wdt_expire = 1'b0;
    wait_cyc(2);
    expect_hi(1'b1, "R9");
    wait_cyc(HOLD - 10);
    expect_hi(1'b1, "R9");
    wait_cyc(20);
    expect_hi(1'b0, "R9");

    cur_req = "R8";
    wait_cyc(10);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule